// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between a processor register port and the frame engine of a time-division audio codec link. It lets software read and write the control registers of up to four codecs one at a time. A lock bit is taken by reading it, so only one agent drives a codec cycle at a time. A codec access that software makes while it holds the lock becomes a command, which the block presents to the output serializer for exactly one frame. For a read, the block then watches the status frames decoded on the input side for a reply whose echoed index matches the command.

A codec read is split in two. The first access returns whatever the read buffer holds and starts the link read. When the reply lands, software takes the lock again and reads the same address a second time to collect the data, and that access starts another link read. If no matching reply arrives in time, the buffer is filled with all ones in its low half and a sticky timeout flag is raised. Completion flags for writes and reads are cleared by writing ones, and each of them can drive the interrupt line.

Top module: `codec_reg_ctrl`

## Requirements
- R1: After reset the lock reads 0, the status register reads 0, the enable register reads 0, `cmd_valid_o` and `irq_o` are 0, and a codec-window read returns 0.
- R2: A read of the lock register (offset 0x000, bit 0) returns the lock value at that moment and leaves the lock at 1.
- R3: Writing 0 to lock bit 0 releases the lock, and the lock clears itself in the cycle a codec cycle completes (write sent, read answered or read timed out).
- R4: A codec-window access made while the lock is 0, or while a codec cycle is still open, is ignored: no command is presented and the read buffer is unchanged.
- R5: An accepted codec access raises `cmd_valid_o` at the first `frame_start_i` after it and drops it at the next one. While it is high, `cmd_idx_o` = addr[7:1], `cmd_cid_o` = addr[10:8]-2, `cmd_rd_o` = 1 for a read, and `cmd_data_o` = wdata[15:0].
- R6: A codec write completes at the frame start that ends its command frame and sets status bit 0 (command done).
- R7: A codec-window read returns {16'h0, read buffer} in the same cycle and, when accepted, starts a link read with `cmd_rd_o` = 1.
- R8: While a read waits, a `resp_valid_i` pulse is accepted only if `resp_idx_i` equals the index sent. An accepted reply loads `resp_data_i` into the read buffer and sets status bit 1 (status done).
- R9: If no matching reply arrives before the fourth frame start after the command frame, the read completes at that frame start with the read buffer set to 16'hFFFF (the codec-window read then returns 0x0000_FFFF), and status bit 2 (timeout) is set.
- R10: Status bits (offset 0x004) stay set until software writes 1 to them. Writing 0 to a bit has no effect on it.
- R11: `irq_o` = (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1), where the enable register sits at offset 0x008.
- R12: The codec window covers addresses 0x200 to 0x5FE, even addresses only. Pages 0x2xx, 0x3xx, 0x4xx and 0x5xx select codec ids 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobe cycle |
| frame_start_i | input | 1 | One-cycle pulse at each link frame boundary |
| resp_valid_i | input | 1 | Input frame carried valid status index and data |
| resp_idx_i | input | 7 | Echoed register index from input slot 1 |
| resp_data_i | input | 16 | Status data from input slot 2 |
| cmd_valid_o | output | 1 | Command slots valid for the current frame |
| cmd_rd_o | output | 1 | Command direction, 1 = read |
| cmd_idx_o | output | 7 | Codec register index |
| cmd_cid_o | output | 2 | Target codec id |
| cmd_data_o | output | 16 | Write data for slot 2 |
| irq_o | output | 1 | Enabled completion interrupt |

## Verification
A wrong sequencer state shows at the frame boundary: `cmd_valid_o` rises a frame early or late, or stays up for two frames, and that is visible one cycle after the `frame_start_i` pulse. A stale index register lets a mismatched reply complete the read, which shows as the status-done bit and a changed buffer value right after the pulse. A miscounted timeout shows as the timeout bit appearing at the third or fifth frame start instead of the fourth. A lock that fails to release shows on the next lock read, which returns 1 instead of 0.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ARM, S_SEND, S_WAIT} seq_state_e;
  localparam logic [11:0] LOCK_OFS = 12'h000;
  localparam logic [11:0] STAT_OFS = 12'h004;
  localparam logic [11:0] CTRL_OFS = 12'h008;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned IEN_W  = 2;
endpackage

// File: rtl/ccr_lock.sv
module ccr_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic rel_i,
  input  logic cpl_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_o <= 1'b0;
    else if (cpl_i) lock_o <= 1'b0;
    else if (rd_i)  lock_o <= 1'b1;
    else if (rel_i) lock_o <= 1'b0;
  end

  p_cpl_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_i |=> !lock_o);
  p_rd_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cpl_i) |=> lock_o);
endmodule

// File: rtl/ccr_status.sv
module ccr_status import ccr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_cmd_i,
  input  logic              set_sts_i,
  input  logic              set_tmo_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] set_w;
  assign set_w = {set_tmo_i, set_sts_i, set_cmd_i};

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[b] <= 1'b0;
      else if (set_w[b]) stat_o[b] <= 1'b1;
      else if (clr_i[b]) stat_o[b] <= 1'b0;
    end
  end

  p_tmo_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_tmo_i |=> stat_o[2]);
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !set_cmd_i) |=> !stat_o[0]);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[1] && !clr_i[1]) |=> stat_o[1]);
endmodule

// File: rtl/ccr_seq.sv
module ccr_seq import ccr_pkg::*; #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned SLOT_W     = 16,
  parameter int unsigned CID_W      = 2,
  parameter int unsigned TMO_FRAMES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SLOT_W-1:0] data_i,
  input  logic [CID_W-1:0]  cid_i,
  input  logic              frame_start_i,
  input  logic              resp_valid_i,
  input  logic [IDX_W-1:0]  resp_idx_i,
  input  logic [SLOT_W-1:0] resp_data_i,
  output logic              idle_o,
  output logic              cmd_valid_o,
  output logic              cmd_rd_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [SLOT_W-1:0] cmd_data_o,
  output logic [CID_W-1:0]  cmd_cid_o,
  output logic              wr_done_o,
  output logic              rd_done_o,
  output logic              tmo_o,
  output logic [SLOT_W-1:0] rbuf_o
);
  localparam int unsigned CNT_W = $clog2(TMO_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_FRAMES - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic match_w;

  assign match_w   = resp_valid_i && (resp_idx_i == cmd_idx_o);
  assign idle_o    = (state_q == S_IDLE);
  assign cmd_valid_o = (state_q == S_SEND);
  assign wr_done_o = (state_q == S_SEND) && frame_start_i && !cmd_rd_o;
  assign rd_done_o = (state_q == S_WAIT) && match_w;
  assign tmo_o     = (state_q == S_WAIT) && !match_w && frame_start_i && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_ARM;
      S_ARM:  if (frame_start_i) state_d = S_SEND;
      S_SEND: if (frame_start_i) state_d = cmd_rd_o ? S_WAIT : S_IDLE;
      S_WAIT: if (rd_done_o || tmo_o) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      cmd_rd_o   <= 1'b0;
      cmd_idx_o  <= '0;
      cmd_data_o <= '0;
      cmd_cid_o  <= '0;
      rbuf_o     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        cmd_rd_o   <= rd_i;
        cmd_idx_o  <= idx_i;
        cmd_data_o <= data_i;
        cmd_cid_o  <= cid_i;
      end
      if (state_q == S_SEND) cnt_q <= '0;
      else if (state_q == S_WAIT && frame_start_i) cnt_q <= cnt_q + 1'b1;
      if (rd_done_o)  rbuf_o <= resp_data_i;
      else if (tmo_o) rbuf_o <= '1;
    end
  end

  p_one_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_done_o, rd_done_o, tmo_o}));
  p_hold_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !frame_start_i) |=> (cmd_valid_o && $stable(cmd_idx_o) && $stable(cmd_rd_o)));
  p_tmo_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> (rbuf_o == '1));
  p_rd_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> (rbuf_o == $past(resp_data_i)));
endmodule

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl import ccr_pkg::*; #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned SLOT_W     = 16,
  parameter int unsigned CID_W      = 2,
  parameter int unsigned TMO_FRAMES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_start_i,
  input  logic              resp_valid_i,
  input  logic [IDX_W-1:0]  resp_idx_i,
  input  logic [SLOT_W-1:0] resp_data_i,
  output logic              cmd_valid_o,
  output logic              cmd_rd_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [CID_W-1:0]  cmd_cid_o,
  output logic [SLOT_W-1:0] cmd_data_o,
  output logic              irq_o
);
  localparam logic [2:0] PAGE_LO = 3'd2;
  localparam logic [2:0] PAGE_HI = 3'd5;

  logic sel_lock, sel_stat, sel_ctrl, sel_codec;
  logic rd_acc, wr_acc, lock_q, idle_w, start_w;
  logic wr_done, rd_done, tmo;
  logic [2:0] page_w, cid_w;
  logic [STAT_W-1:0] stat_q;
  logic [IEN_W-1:0]  ien_q;
  logic [SLOT_W-1:0] rbuf_w;
  logic unused_bits;

  assign unused_bits = ^{wdata_i[DATA_W-1:SLOT_W], cid_w[2]};

  assign page_w    = addr_i[10:8];
  assign cid_w     = page_w - PAGE_LO;
  assign sel_lock  = (addr_i == LOCK_OFS);
  assign sel_stat  = (addr_i == STAT_OFS);
  assign sel_ctrl  = (addr_i == CTRL_OFS);
  assign sel_codec = !addr_i[11] && !addr_i[0] && (page_w >= PAGE_LO) && (page_w <= PAGE_HI);
  assign rd_acc    = req_i && !we_i;
  assign wr_acc    = req_i && we_i;
  assign start_w   = req_i && sel_codec && lock_q && idle_w;

  ccr_lock u_lock (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .rd_i  (rd_acc && sel_lock),
    .rel_i (wr_acc && sel_lock && !wdata_i[0]),
    .cpl_i (wr_done || rd_done || tmo),
    .lock_o(lock_q)
  );

  ccr_seq #(.IDX_W(IDX_W), .SLOT_W(SLOT_W), .CID_W(CID_W), .TMO_FRAMES(TMO_FRAMES)) u_seq (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .start_i (start_w), .rd_i (!we_i),
    .idx_i (addr_i[IDX_W:1]), .data_i (wdata_i[SLOT_W-1:0]), .cid_i (cid_w[CID_W-1:0]),
    .frame_start_i (frame_start_i), .resp_valid_i (resp_valid_i),
    .resp_idx_i (resp_idx_i), .resp_data_i (resp_data_i),
    .idle_o (idle_w), .cmd_valid_o (cmd_valid_o), .cmd_rd_o (cmd_rd_o),
    .cmd_idx_o (cmd_idx_o), .cmd_data_o (cmd_data_o), .cmd_cid_o (cmd_cid_o),
    .wr_done_o (wr_done), .rd_done_o (rd_done), .tmo_o (tmo), .rbuf_o (rbuf_w)
  );

  ccr_status u_stat (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_cmd_i (wr_done), .set_sts_i (rd_done), .set_tmo_i (tmo),
    .clr_i ((wr_acc && sel_stat) ? wdata_i[STAT_W-1:0] : '0),
    .stat_o (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ien_q <= '0;
    else if (wr_acc && sel_ctrl) ien_q <= wdata_i[IEN_W-1:0];
  end

  assign irq_o = |(stat_q[IEN_W-1:0] & ien_q);

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      if (sel_lock)       rdata_o = DATA_W'(lock_q);
      else if (sel_stat)  rdata_o = DATA_W'(stat_q);
      else if (sel_ctrl)  rdata_o = DATA_W'(ien_q);
      else if (sel_codec) rdata_o = DATA_W'(rbuf_w);
    end
  end

  p_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sel_codec && !lock_q && idle_w) |=> idle_w);
  p_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/codec_reg_ctrl_tb.sv
module codec_reg_ctrl_tb;
  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, fs = 0, rv = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [6:0] ridx = 0, cmd_idx;
  logic [15:0] rdat = 0, cmd_data;
  logic cmd_valid, cmd_rd, irq;
  logic [1:0] cmd_cid;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [15:0] rbuf_exp = 0;

  always #5 clk = ~clk;

  codec_reg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .frame_start_i(fs), .resp_valid_i(rv),
    .resp_idx_i(ridx), .resp_data_i(rdat), .cmd_valid_o(cmd_valid), .cmd_rd_o(cmd_rd),
    .cmd_idx_o(cmd_idx), .cmd_cid_o(cmd_cid), .cmd_data_o(cmd_data), .irq_o(irq));

  function automatic logic [11:0] caddr(input logic [1:0] cid, input logic [6:0] idx);
    return 12'h200 + {2'b00, cid, 8'h00} + {4'h0, idx, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic frame();
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic reply(input logic [6:0] i, input logic [15:0] d);
    @(negedge clk); rv = 1; ridx = i; rdat = d;
    @(negedge clk); rv = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    chk("R1 cmd_valid", {31'h0, cmd_valid}, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    bus_rd(12'h004, d); chk("R1 status", d, 0);
    bus_rd(12'h008, d); chk("R1 ien", d, 0);
    bus_rd(caddr(0, 7'h10), d); chk("R1 codec buf", d, 0);

    // R2 read-to-set lock, R3 release
    bus_rd(12'h000, d); chk("R2 first lock rd", d, 0);
    bus_rd(12'h000, d); chk("R2 second lock rd", d, 1);
    bus_wr(12'h000, 0);
    bus_rd(12'h000, d); chk("R3 released", d, 0);
    bus_wr(12'h000, 0);

    // R4 ignored without lock
    bus_wr(caddr(1, 7'h26), 32'h1000);
    frame(); chk("R4 no cmd", {31'h0, cmd_valid}, 0);
    frame(); chk("R4 still no cmd", {31'h0, cmd_valid}, 0);
    bus_rd(12'h004, d); chk("R4 no status", d, 0);

    // R5 R6 R11 write
    bus_rd(12'h000, d); chk("R2 lock for write", d, 0);
    bus_wr(12'h008, 32'h1);
    bus_wr(caddr(3, 7'h2A), 32'hDEAD_BEEF);
    chk("R5 armed not valid", {31'h0, cmd_valid}, 0);
    bus_wr(caddr(2, 7'h05), 32'h1111);  // busy: ignored, R4
    frame();
    chk("R5 valid", {31'h0, cmd_valid}, 1);
    chk("R5 rd", {31'h0, cmd_rd}, 0);
    chk("R5 idx", {25'h0, cmd_idx}, 32'h2A);
    chk("R12 cid", {30'h0, cmd_cid}, 3);
    chk("R5 data", {16'h0, cmd_data}, 32'hBEEF);
    frame();
    chk("R5 one frame", {31'h0, cmd_valid}, 0);
    bus_rd(12'h004, d); chk("R6 cmd done", d, 1);
    chk("R11 irq", {31'h0, irq}, 1);
    frame(); chk("R4 busy access dropped", {31'h0, cmd_valid}, 0);
    bus_rd(12'h000, d); chk("R3 self clear", d, 0);
    bus_wr(12'h004, 32'h6);
    bus_rd(12'h004, d); chk("R10 write0 no effect", d, 1);
    bus_wr(12'h004, 32'h1);
    bus_rd(12'h004, d); chk("R10 w1c", d, 0);
    chk("R11 irq clear", {31'h0, irq}, 0);

    // R7 R8 read with mismatch then match
    bus_wr(12'h008, 32'h2);
    bus_rd(caddr(0, 7'h7C), d); chk("R7 dummy", d, 0);
    frame();
    chk("R7 rd cmd", {31'h0, cmd_rd}, 1);
    chk("R12 cid0", {30'h0, cmd_cid}, 0);
    chk("R7 idx", {25'h0, cmd_idx}, 32'h7C);
    frame();
    reply(7'h7B, 16'h5555);
    bus_rd(12'h004, d); chk("R8 mismatch ignored", d, 0);
    reply(7'h7C, 16'hA5C3);
    bus_rd(12'h004, d); chk("R8 sts done", d, 2);
    chk("R11 irq sts", {31'h0, irq}, 1);
    bus_wr(12'h004, 32'h2);
    bus_rd(12'h000, d); chk("R3 read cpl", d, 0);

    // R9 timeout on second read
    bus_rd(caddr(0, 7'h7C), d); chk("R7 second read data", d, 32'h0000_A5C3);
    frame(); frame();
    for (int k = 0; k < 3; k++) frame();
    bus_rd(12'h004, d); chk("R9 no early tmo", d, 0);
    frame();
    bus_rd(12'h004, d); chk("R9 tmo bit", d, 4);
    bus_rd(12'h000, d); chk("R3 tmo cpl", d, 0);
    bus_rd(caddr(1, 7'h01), d); chk("R9 fill", d, 32'h0000_FFFF);
    rbuf_exp = 16'hFFFF;
    // that read was accepted: let it time out
    frame(); frame();
    for (int k = 0; k < 4; k++) frame();
    bus_wr(12'h004, 32'h7);
    bus_wr(12'h008, 32'h0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [1:0] cid; logic [6:0] idx; logic [15:0] dat; bit isrd, ok;
      cid = 2'($urandom); idx = 7'($urandom); dat = 16'($urandom);
      isrd = 1'($urandom); ok = 1'($urandom);
      bus_rd(12'h000, d); chk("R2 rnd lock", d, 0);
      if (isrd) begin
        bus_rd(caddr(cid, idx), d); chk("R7 rnd buf", d, {16'h0, rbuf_exp});
      end else bus_wr(caddr(cid, idx), {16'h0, dat});
      frame();
      chk("R5 rnd valid", {31'h0, cmd_valid}, 1);
      chk("R5 rnd idx", {25'h0, cmd_idx}, {25'h0, idx});
      chk("R12 rnd cid", {30'h0, cmd_cid}, {30'h0, cid});
      chk("R5 rnd rd", {31'h0, cmd_rd}, {31'h0, isrd});
      if (!isrd) chk("R5 rnd data", {16'h0, cmd_data}, {16'h0, dat});
      frame();
      if (!isrd) begin
        bus_rd(12'h004, d); chk("R6 rnd", d, 1);
      end else if (ok) begin
        reply(idx ^ 7'h01, ~dat);
        reply(idx, dat); rbuf_exp = dat;
        bus_rd(12'h004, d); chk("R8 rnd", d, 2);
      end else begin
        for (int k = 0; k < 4; k++) frame();
        rbuf_exp = 16'hFFFF;
        bus_rd(12'h004, d); chk("R9 rnd", d, 4);
      end
      bus_wr(12'h004, 32'h7);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule